// File: doc/BRIEF.md
# Push-Pull Transformer Driver Oscillator

This block generates the two gate-drive phases for a center-tapped transformer primary in an isolated supply. Each phase closes one half of the primary in turn, so the core is driven alternately in both directions. A free-running period counter on the system clock sets the switching frequency. A one-bit supply-mode input picks one of two frequencies: a faster one for the higher logic supply and a slower one for the lower logic supply.

Between the end of one phase and the start of the other, the block always inserts a guard interval of `DEAD_CYC` clocks with both phases off. Nothing switches until a supply-good flag reports that the primary supply has reached its start-up level. Losing that flag, or asserting reset, turns both phases off at once. A mode change is held back until the running period ends, so a period is never cut short.

Top module: `xfmr_pushpull_osc`

## Requirements
- R1: Within every period the block produces exactly one phase-A pulse followed by exactly one phase-B pulse.
- R2: The period, measured from one phase-A rising edge to the next, is P = floor(CLK_HZ / FREQ_HI_HZ) clocks when `modeSel` = 1 and P = floor(CLK_HZ / FREQ_LO_HZ) clocks when `modeSel` = 0.
- R3: `phaseDrvA` and `phaseDrvB` are never high in the same cycle.
- R4: With H = floor(P/2), phase A is high for H − DEAD_CYC clocks and phase B for P − H − DEAD_CYC clocks. This also holds for the first pulse after a start.
- R5: Each falling edge of one phase is followed by exactly DEAD_CYC clocks with both phases low before the other phase rises.
- R6: While reset is asserted, both phases and `running` are low. The first clock edge that samples `supplyGood` low drives both phases and `running` low, and they stay low while `supplyGood` stays low.
- R7: The first clock edge that samples `supplyGood` high after an idle time sets `running`. The next edge raises phase A, and a new period then begins.
- R8: A change of `modeSel` takes effect only at the next period boundary. The period in progress completes at its old length, and every later period has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | Primary supply is above the start-up level (synchronous to clk) |
| modeSel | input | 1 | Frequency select: 1 = higher-supply (faster) setting, 0 = lower-supply (slower) setting |
| phaseDrvA | output | 1 | Gate drive for the first half of the primary |
| phaseDrvB | output | 1 | Gate drive for the second half of the primary |
| running | output | 1 | High while the oscillator is switching |

## Verification
A period counter or latched mode that goes wrong shows up within one period. It appears as a period that does not match either mode's length, or as a phase pulse whose width or following gap is off by the counter's error. The bench measures these at every edge. A decode error that lets the phases touch is seen in the first cycle where both are high. A fault in the start-up gating shows at the first or second edge after `supplyGood` changes. The supply-loss and mode-change sweeps step through every cycle offset within a period in both modes, so an error tied to one counter value cannot hide between samples.

// File: rtl/xpp_pkg.sv
package xpp_pkg;

  // Supply-level setting that selects the switching frequency
  typedef enum logic {
    MODE_LOW  = 1'b0,
    MODE_HIGH = 1'b1
  } supplyMode_e;

  // Strobes from the control to the output stage
  typedef struct packed {
    logic phaseAOn;
    logic phaseBOn;
  } phaseStrobe_t;

  // Clocks per switching period (rounded down)
  function automatic int periodCycles(input int clkHz, input int freqHz);
    return clkHz / freqHz;
  endfunction

endpackage

// File: rtl/xpp_ctrl.sv
module xpp_ctrl
  import xpp_pkg::*;
#(
  parameter int PERIOD_LO = 757,
  parameter int PERIOD_HI = 500,
  parameter int DEAD_CYC  = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         supplyGood,
  input  supplyMode_e  modeSel,
  output phaseStrobe_t strobe,
  output logic         active
);

  localparam int PERIOD_MAX = (PERIOD_LO > PERIOD_HI) ? PERIOD_LO : PERIOD_HI;
  localparam int CNT_W      = $clog2(PERIOD_MAX);
  localparam int NUM_MODES  = 2;

  // Window bounds per mode
  logic [CNT_W-1:0] lastCnt [NUM_MODES];
  logic [CNT_W-1:0] aStop   [NUM_MODES];
  logic [CNT_W-1:0] bStart  [NUM_MODES];
  logic [CNT_W-1:0] bStop   [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_modeTab
    localparam int PER  = (m == 1) ? PERIOD_HI : PERIOD_LO;
    localparam int HALF = PER / 2;
    assign lastCnt[m] = CNT_W'(PER - 1);
    assign aStop[m]   = CNT_W'(HALF - DEAD_CYC);
    assign bStart[m]  = CNT_W'(HALF);
    assign bStop[m]   = CNT_W'(PER - DEAD_CYC);
  end

  supplyMode_e      curMode;
  logic             modeIdx;
  logic [CNT_W-1:0] cnt;
  logic             atLast;

  assign modeIdx = curMode;
  assign atLast  = (cnt == lastCnt[modeIdx]);

  // Period counter; mode is sampled only while idle or at the wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      cnt     <= '0;
      curMode <= MODE_LOW;
    end else begin
      active <= supplyGood;
      if (!active || atLast) begin
        cnt     <= '0;
        curMode <= modeSel;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Phase windows, gated by the live supply flag
  always_comb begin
    strobe = '0;
    if (active && supplyGood) begin
      strobe.phaseAOn = (cnt < aStop[modeIdx]);
      strobe.phaseBOn = (cnt >= bStart[modeIdx]) && (cnt < bStop[modeIdx]);
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cnt <= lastCnt[modeIdx]));

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (active && !atLast) |=> $stable(curMode));

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> (cnt == '0));

endmodule

// File: rtl/xpp_datapath.sv
module xpp_datapath
  import xpp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  phaseStrobe_t strobe,
  output logic         drvA,
  output logic         drvB
);

  // Registered drive with a cross interlock as a last guard
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvA <= 1'b0;
      drvB <= 1'b0;
    end else begin
      drvA <= strobe.phaseAOn && !drvB;
      drvB <= strobe.phaseBOn && !drvA;
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(drvA && drvB));

  // The control's window already left the opposite phase off
  assert_gap_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phaseAOn |-> !drvB);

  assert_gap_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phaseBOn |-> !drvA);

endmodule

// File: rtl/xfmr_pushpull_osc.sv
module xfmr_pushpull_osc
  import xpp_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int FREQ_HI_HZ = 500_000,
  parameter int FREQ_LO_HZ = 330_000,
  parameter int DEAD_CYC   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic modeSel,
  output logic phaseDrvA,
  output logic phaseDrvB,
  output logic running
);

  localparam int PERIOD_HI = periodCycles(CLK_HZ, FREQ_HI_HZ);
  localparam int PERIOD_LO = periodCycles(CLK_HZ, FREQ_LO_HZ);

  phaseStrobe_t strobe;

  xpp_ctrl #(
    .PERIOD_LO (PERIOD_LO),
    .PERIOD_HI (PERIOD_HI),
    .DEAD_CYC  (DEAD_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .modeSel    (supplyMode_e'(modeSel)),
    .strobe     (strobe),
    .active     (running)
  );

  xpp_datapath u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .drvA   (phaseDrvA),
    .drvB   (phaseDrvB)
  );

  assert_supply_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> (!phaseDrvA && !phaseDrvB && !running));

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(running) && supplyGood) |=> phaseDrvA);

endmodule

// File: tb/xfmr_pushpull_osc_bench.sv
module xfmr_pushpull_osc_bench;

  localparam int CLK_HZ = 10_500_000;
  localparam int F_HI   = 500_000;
  localparam int F_LO   = 330_000;
  localparam int DEAD   = 3;
  localparam int P_HI   = CLK_HZ / F_HI;   // 21
  localparam int P_LO   = CLK_HZ / F_LO;   // 31

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0;
  logic modeSel = 1'b0;
  logic drvA, drvB, running;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xfmr_pushpull_osc #(
    .CLK_HZ     (CLK_HZ),
    .FREQ_HI_HZ (F_HI),
    .FREQ_LO_HZ (F_LO),
    .DEAD_CYC   (DEAD)
  ) u_xfmr_pushpull_osc (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .modeSel    (modeSel),
    .phaseDrvA  (drvA),
    .phaseDrvB  (drvB),
    .running    (running)
  );

  function automatic int perOf(input logic m);
    return m ? P_HI : P_LO;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for n rising edges of phase A, sampled at negedges
  task automatic syncRise(input int n);
    logic pa;
    int seen = 0;
    int guard = 0;
    pa = drvA;
    while (seen < n && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (drvA && !pa) seen++;
      pa = drvA;
    end
  endtask

  // Measure nRises periods after a reference rise; optional mode change
  task automatic runPeriods(input int expFirst, input int expRest, input int nRises,
                            input int changeAt, input logic newMode);
    logic pa, pb, a, b;
    int cyc = 0, k = -1, guard = 0;
    int riseA = 0, fallA = 0, riseB = 0, fallB = 0, curP = expFirst, bRises = 0;
    bit haveFallB = 1'b0, haveRiseB = 1'b0, overlap = 1'b0;
    pa = drvA;
    pb = drvB;
    while (k < nRises && guard < 5000) begin
      @(negedge clk);
      cyc++;
      guard++;
      a = drvA;
      b = drvB;
      if (a && b) overlap = 1'b1;
      if (a && !pa) begin
        if (k >= 0) begin
          chk("R2 period", cyc - riseA, (k == 0) ? expFirst : expRest);
          if (haveFallB) chk("R5 gap B to A", cyc - fallB, DEAD);
        end
        k++;
        curP = (k == 0) ? expFirst : expRest;
        riseA = cyc;
      end
      if (!a && pa && k >= 0) begin
        chk("R4 phase A width", cyc - riseA, curP / 2 - DEAD);
        fallA = cyc;
      end
      if (b && !pb && k >= 0) begin
        chk("R5 gap A to B", cyc - fallA, DEAD);
        riseB = cyc;
        haveRiseB = 1'b1;
        if (k < nRises) bRises++;
      end
      if (!b && pb && haveRiseB) begin
        chk("R4 phase B width", cyc - riseB, curP - curP / 2 - DEAD);
        fallB = cyc;
        haveFallB = 1'b1;
      end
      if (k == 0 && changeAt >= 0 && cyc - riseA == changeAt) modeSel = newMode;
      pa = a;
      pb = b;
    end
    chk("R2 window completed", k, nRises);
    chk("R3 no overlap", int'(overlap), 0);
    chk("R1 one B pulse per period", bRises, nRises);
  endtask

  initial begin
    int n;
    // Reset state
    repeat (3) @(negedge clk);
    chk("R6 reset outputs", {drvA, drvB, running}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 idle with supply low", {drvA, drvB, running}, 0);

    // First start
    supplyGood = 1'b1;
    @(negedge clk);
    chk("R7 running after start", running, 1);
    chk("R7 phase A not yet on", drvA, 0);
    @(negedge clk);
    chk("R7 phase A on", drvA, 1);

    // Steady periods in both modes
    for (int m = 0; m < 2; m++) begin
      modeSel = logic'(m);
      syncRise(2);
      runPeriods(perOf(modeSel), perOf(modeSel), 4, -1, modeSel);
    end

    // Mode change swept over every offset in the period, both directions
    for (int d = 0; d < 2; d++) begin
      logic oldM;
      oldM = logic'(d);
      for (int off = 0; off <= perOf(oldM) - 2; off++) begin
        modeSel = oldM;
        syncRise(2);
        runPeriods(perOf(oldM), perOf(!oldM), 3, off, !oldM); // R8
      end
    end

    // Supply loss at every offset, then restart, in both modes
    for (int m = 0; m < 2; m++) begin
      int p;
      modeSel = logic'(m);
      syncRise(2);
      p = perOf(modeSel);
      for (int off = 0; off < p; off++) begin
        syncRise(1);
        repeat (off) @(negedge clk);
        supplyGood = 1'b0;
        @(negedge clk);
        chk("R6 off after supply loss", {drvA, drvB, running}, 0);
        repeat (3) @(negedge clk);
        chk("R6 stays off", {drvA, drvB, running}, 0);
        supplyGood = 1'b1;
        @(negedge clk);
        chk("R7 running on restart", running, 1);
        chk("R7 phase A waits one edge", drvA, 0);
        @(negedge clk);
        chk("R7 phase A on restart", drvA, 1);
        n = 0;
        while (drvA && n < 1000) begin
          n++;
          @(negedge clk);
        end
        chk("R4 first pulse full width", n, p / 2 - DEAD);
      end
    end

    // Reset in the middle of a pulse
    syncRise(1);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R6 reset mid pulse", {drvA, drvB, running}, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 running after reset release", running, 1);
    @(negedge clk);
    chk("R7 phase A after reset release", drvA, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule